// File: doc/BRIEF.md
# Duty-Cycled Receiver Listen Sequencer

This block is a timer-driven controller for a radio receiver. While listening is enabled, it alternates the receiver between an idle phase, with the receiver off, and a receive window, with the receiver on. Each phase lasts an 8-bit coefficient times a time base. The time base is chosen per phase by a 2-bit resolution code and is counted in ticks of an external base tick. The receive window includes the receiver's startup time.

During a receive window the sequencer checks for an acceptable packet. The signal-strength flag is always required, and the sync-match flag is also required when the criterion input is set. The end-action code decides what happens after a packet is accepted:

- The receiver can stay on indefinitely.
- The receiver can wait for a payload-ready or timeout event and then request a switch to a configured operating mode.
- The receiver can wait for the same event and then resume the listen cycle. In this case it raises a discard pulse at the next receive wakeup, so the buffered data is thrown away.

The configuration fields are held outside the block. Their usual power-on values are idle resolution 10, receive resolution 01, idle coefficient 0xF5 and receive coefficient 0x20.

Top module: `listen_seq`

## Requirements
- R1: After reset, and one cycle after `listen_en` is low in any state, `phase` = 0 (off), and `rx_on`, `mode_req` and `fifo_flush` are 0. One cycle after `listen_en` rises, `phase` = 1 (idle).
- R2: The idle phase lasts `idle_coef` × U base ticks. U depends on `idle_res`: 01 gives 1, 10 gives 64, 11 gives 4096, and the reserved code 00 falls back to 1.
- R3: The receive window (`phase` = 2) lasts `rx_coef` × U base ticks, with U decoded from `rx_res` as in R2. `rx_on` is 1 throughout the window and 0 during idle.
- R4: A coefficient of 0 gives a phase of one time-base unit.
- R5: If no packet is accepted by the end of the receive window, the sequencer returns to idle for a full idle length and the receiver turns off.
- R6: A packet is accepted during the receive window in one cycle. With `need_sync` = 0, `rssi_hit` alone is enough. With `need_sync` = 1, both `rssi_hit` and `sync_hit` are needed.
- R7: With `end_act` = 00, acceptance moves to `phase` = 4 (halted with the receiver on). That phase ignores `payload_ready` and `rx_timeout` and leaves only when `listen_en` is cleared.
- R8: With `end_act` = 01, acceptance moves to `phase` = 3 (hold, receiver on). A `payload_ready` or `rx_timeout` then moves to `phase` = 5, with `mode_req` = 1 and `rx_on` = 0, until `listen_en` is cleared.
- R9: With `end_act` = 10, hold ends on `payload_ready` or `rx_timeout` by returning to idle. `fifo_flush` is 1 for exactly the first cycle of the next receive window.
- R10: The reserved `end_act` = 11 behaves as 01.
- R11: Acceptance takes priority over window expiry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| listen_en | input | 1 | Listen enable; low forces the off state |
| tick | input | 1 | Base time tick (finest resolution unit) |
| idle_res | input | 2 | Idle phase resolution code |
| rx_res | input | 2 | Receive phase resolution code |
| idle_coef | input | 8 | Idle phase coefficient |
| rx_coef | input | 8 | Receive phase coefficient |
| need_sync | input | 1 | Acceptance criterion: also require sync match |
| end_act | input | 2 | Action after acceptance |
| rssi_hit | input | 1 | Signal strength above threshold |
| sync_hit | input | 1 | Sync/address matched |
| payload_ready | input | 1 | Payload-ready event |
| rx_timeout | input | 1 | Receive timeout event |
| rx_on | output | 1 | Receiver enable |
| phase | output | 3 | Current phase: 0 off, 1 idle, 2 receive, 3 hold, 4 halted-on, 5 mode switch |
| mode_req | output | 1 | Request to leave listen for the operating mode |
| fifo_flush | output | 1 | Discard buffered data (one cycle) |

## Verification
Every result is registered once, so each output reflects a stimulus one clock edge after the edge that samples it. The stimulus is driven on the falling edge, and the bench samples on the next falling edge, which lies after exactly one rising edge.

Phase lengths are measured by counting the falling edges on which `phase` holds its value. With a tick on every cycle, the count must equal the coefficient times the unit. `fifo_flush` is checked on the first falling edge that shows the receive phase, and again one edge later, where it must be 0.

// File: rtl/listen_pkg.sv
// Shared types and decode helpers for the listen sequencer.
// Assumes the base tick is the finest resolution unit.
package listen_pkg;

    typedef enum logic [2:0] {
        PH_OFF  = 3'd0,
        PH_IDLE = 3'd1,
        PH_RX   = 3'd2,
        PH_HOLD = 3'd3,
        PH_STAY = 3'd4,
        PH_DONE = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        END_KEEP   = 2'b00,
        END_MODE   = 2'b01,
        END_RESUME = 2'b10,
        END_RSVD   = 2'b11
    } end_e;

    // Number of base ticks per unit for a resolution code; reserved 00 maps to 1.
    function automatic int unsigned res_ticks(input logic [1:0] code,
                                              input int unsigned mid,
                                              input int unsigned hi);
        case (code)
            2'b10:   return mid;
            2'b11:   return hi;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/listen_prescale.sv
// Divides the base tick into resolution units. Emits a one-cycle unit pulse
// when the selected number of ticks has elapsed. Assumes clr restarts the count.
module listen_prescale #(
    parameter int unsigned MID_TICKS = 64,
    parameter int unsigned HI_TICKS  = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic       tick,
    input  logic [1:0] res_code,
    output logic       unit
);
    localparam int unsigned PW = $clog2(HI_TICKS) + 1;

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] lim;

    // Decode the selected resolution into a tick limit.
    always_comb lim = PW'(listen_pkg::res_ticks(res_code, MID_TICKS, HI_TICKS));

    // Unit boundary reached on this tick.
    always_comb unit = run && tick && (cnt_q == lim - PW'(1));

    // Tick counter within the current unit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (run && tick)
            cnt_q <= unit ? '0 : cnt_q + PW'(1);
    end
endmodule

// File: rtl/listen_phase_cnt.sv
// Counts resolution units against a coefficient and flags the last unit.
// A coefficient of zero is treated as one unit so the phase always ends.
module listen_phase_cnt #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          unit,
    input  logic [CW-1:0] coef,
    output logic          done
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    // Index of the final unit, clamped for a zero coefficient.
    always_comb last = (coef == '0) ? '0 : coef - CW'(1);

    // Phase ends on the unit pulse of the final unit.
    always_comb done = unit && (cnt_q == last);

    // Unit counter within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (unit)
            cnt_q <= done ? '0 : cnt_q + CW'(1);
    end
endmodule

// File: rtl/listen_accept.sv
// Packet acceptance criterion: strength alone, or strength plus sync match.
module listen_accept (
    input  logic need_sync,
    input  logic rssi_hit,
    input  logic sync_hit,
    output logic accept
);
    // Combine the flags according to the criterion.
    always_comb accept = rssi_hit && (!need_sync || sync_hit);
endmodule

// File: rtl/listen_seq.sv
// Listen sequencer top: alternates idle and receive phases, accepts packets
// and applies the configured end action. Assumes config is static while enabled.
module listen_seq #(
    parameter int unsigned MID_TICKS = 64,
    parameter int unsigned HI_TICKS  = 4096,
    parameter int unsigned CW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          listen_en,
    input  logic          tick,
    input  logic [1:0]    idle_res,
    input  logic [1:0]    rx_res,
    input  logic [CW-1:0] idle_coef,
    input  logic [CW-1:0] rx_coef,
    input  logic          need_sync,
    input  logic [1:0]    end_act,
    input  logic          rssi_hit,
    input  logic          sync_hit,
    input  logic          payload_ready,
    input  logic          rx_timeout,
    output logic          rx_on,
    output logic [2:0]    phase,
    output logic          mode_req,
    output logic          fifo_flush
);
    import listen_pkg::*;

    phase_e        state_q, state_d;
    logic          resume_q, pend_q, flush_q;
    logic          run, clr, unit, done, accept;
    logic [1:0]    res_sel;
    logic [CW-1:0] coef_sel;

    // Pick timing fields for the active phase.
    always_comb begin
        run      = (state_q == PH_IDLE) || (state_q == PH_RX);
        res_sel  = (state_q == PH_RX) ? rx_res  : idle_res;
        coef_sel = (state_q == PH_RX) ? rx_coef : idle_coef;
    end

    listen_prescale #(.MID_TICKS(MID_TICKS), .HI_TICKS(HI_TICKS)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .tick(tick),
        .res_code(res_sel), .unit(unit)
    );

    listen_phase_cnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .unit(unit),
        .coef(coef_sel), .done(done)
    );

    listen_accept u_acc (
        .need_sync(need_sync), .rssi_hit(rssi_hit), .sync_hit(sync_hit),
        .accept(accept)
    );

    // Next-state selection; acceptance outranks window expiry.
    always_comb begin
        state_d = state_q;
        if (!listen_en) begin
            state_d = PH_OFF;
        end else begin
            case (state_q)
                PH_OFF:  state_d = PH_IDLE;
                PH_IDLE: if (done) state_d = PH_RX;
                PH_RX: begin
                    if (accept)
                        state_d = (end_act == END_KEEP) ? PH_STAY : PH_HOLD;
                    else if (done)
                        state_d = PH_IDLE;
                end
                PH_HOLD: if (payload_ready || rx_timeout)
                             state_d = resume_q ? PH_IDLE : PH_DONE;
                default: state_d = state_q;
            endcase
        end
    end

    // Counters restart on every phase change.
    always_comb clr = (state_d != state_q);

    // State, resume choice and pending discard registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PH_OFF;
            resume_q <= 1'b0;
            pend_q   <= 1'b0;
            flush_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            flush_q <= 1'b0;
            if (state_q == PH_RX && accept)
                resume_q <= (end_act == END_RESUME);
            if (state_d == PH_OFF)
                pend_q <= 1'b0;
            else if (state_q == PH_HOLD && state_d == PH_IDLE)
                pend_q <= 1'b1;
            else if (state_q == PH_IDLE && state_d == PH_RX && pend_q) begin
                pend_q  <= 1'b0;
                flush_q <= 1'b1;
            end
        end
    end

    // Output decode from the registered state.
    always_comb begin
        phase      = state_q;
        rx_on      = (state_q == PH_RX) || (state_q == PH_HOLD) || (state_q == PH_STAY);
        mode_req   = (state_q == PH_DONE);
        fifo_flush = flush_q;
    end
endmodule

// File: rtl/listen_seq_chk.sv
// Temporal checks on the listen sequencer ports, bound to every instance.
module listen_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       listen_en,
    input logic       need_sync,
    input logic [1:0] end_act,
    input logic       rssi_hit,
    input logic       sync_hit,
    input logic       payload_ready,
    input logic       rx_timeout,
    input logic       rx_on,
    input logic [2:0] phase,
    input logic       mode_req,
    input logic       fifo_flush
);
    // R1
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !listen_en |=> (phase == 3'd0) && !rx_on && !mode_req);

    // R8
    mode_req_rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_req |-> !rx_on);

    // R7
    keep_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd2) && listen_en && rssi_hit && (!need_sync || sync_hit)
        && (end_act == 2'b00) |=> phase == 3'd4);

    // R7
    keep_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd4) && listen_en |=> (phase == 3'd4) && rx_on);

    // R8
    hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3) && listen_en && (payload_ready || rx_timeout)
        |=> (phase == 3'd1) || (phase == 3'd5));

    // R9
    flush_in_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> (phase == 3'd2) && $rose(rx_on));
endmodule

bind listen_seq listen_seq_chk u_chk (.*);

// File: tb/listen_seq_tb.sv
module listen_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       listen_en = 1'b0;
    logic       tick = 1'b1;
    logic [1:0] idle_res = 2'b01, rx_res = 2'b01;
    logic [7:0] idle_coef = 8'd3, rx_coef = 8'd3;
    logic       need_sync = 1'b0;
    logic [1:0] end_act = 2'b01;
    logic       rssi_hit = 1'b0, sync_hit = 1'b0;
    logic       payload_ready = 1'b0, rx_timeout = 1'b0;
    logic       rx_on, mode_req, fifo_flush;
    logic [2:0] phase;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    listen_seq u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic restart();
        listen_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        listen_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_phase(input int p);
        while (phase != 3'(p)) @(negedge clk);
    endtask

    // idle_res, idle_coef, rx_res, rx_coef, expected idle cycles, expected rx cycles
    localparam int VEC [6][6] = '{
        '{1, 3, 1, 5, 3, 5},
        '{0, 2, 1, 0, 2, 1},
        '{2, 2, 1, 1, 128, 1},
        '{1, 0, 2, 1, 1, 64},
        '{3, 1, 1, 2, 4096, 2},
        '{1, 7, 3, 1, 7, 4096}
    };

    initial begin
        #(8 * 190000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        int rx_bad;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset phase", int'(phase), 0);
        chk("R1 reset rx_on", int'(rx_on), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 still off when disabled", int'(phase), 0);

        // Vector table: phase lengths with no packet accepted.
        foreach (VEC[i]) begin
            idle_res  = 2'(VEC[i][0]);
            idle_coef = 8'(VEC[i][1]);
            rx_res    = 2'(VEC[i][2]);
            rx_coef   = 8'(VEC[i][3]);
            restart();
            chk("R1 idle after enable", int'(phase), 1);
            n = 0;
            while (phase == 3'd1) begin n++; @(negedge clk); end
            chk("R2 R4 idle length", n, VEC[i][4]);
            n = 0; rx_bad = 0;
            while (phase == 3'd2) begin
                if (!rx_on) rx_bad++;
                n++;
                @(negedge clk);
            end
            chk("R3 R4 rx length", n, VEC[i][5]);
            chk("R3 rx_on during rx", rx_bad, 0);
            chk("R5 back to idle", int'(phase), 1);
            chk("R5 rx off in idle", int'(rx_on), 0);
        end

        idle_res = 2'b01; rx_res = 2'b01; idle_coef = 8'd2; rx_coef = 8'd10;

        // R6: criterion with sync required.
        need_sync = 1'b1; end_act = 2'b01;
        restart(); wait_phase(2);
        rssi_hit = 1'b1;
        @(negedge clk);
        chk("R6 rssi alone rejected with sync criterion", int'(phase), 2);
        sync_hit = 1'b1;
        @(negedge clk);
        rssi_hit = 1'b0; sync_hit = 1'b0;
        chk("R6 rssi plus sync accepted", int'(phase), 3);
        chk("R8 rx on in hold", int'(rx_on), 1);
        @(negedge clk);
        chk("R8 hold waits for event", int'(phase), 3);
        payload_ready = 1'b1;
        @(negedge clk);
        payload_ready = 1'b0;
        chk("R8 mode switch phase", int'(phase), 5);
        chk("R8 mode_req", int'(mode_req), 1);
        chk("R8 rx off", int'(rx_on), 0);
        listen_en = 1'b0;
        @(negedge clk);
        chk("R1 disable from mode switch", int'(phase), 0);
        chk("R1 mode_req low", int'(mode_req), 0);

        // R7: keep receiver on, events ignored.
        need_sync = 1'b0; end_act = 2'b00;
        restart(); wait_phase(2);
        rssi_hit = 1'b1;
        @(negedge clk);
        rssi_hit = 1'b0;
        chk("R6 rssi alone accepted", int'(phase), 4);
        payload_ready = 1'b1; rx_timeout = 1'b1;
        @(negedge clk);
        payload_ready = 1'b0; rx_timeout = 1'b0;
        repeat (20) @(negedge clk);
        chk("R7 stays halted", int'(phase), 4);
        chk("R7 rx on", int'(rx_on), 1);

        // R10: reserved action behaves as mode switch, via timeout.
        end_act = 2'b11;
        restart(); wait_phase(2);
        rssi_hit = 1'b1;
        @(negedge clk);
        rssi_hit = 1'b0;
        chk("R10 hold", int'(phase), 3);
        rx_timeout = 1'b1;
        @(negedge clk);
        rx_timeout = 1'b0;
        chk("R10 mode switch", int'(phase), 5);

        // R9: resume, then discard pulse at next wakeup.
        end_act = 2'b10;
        restart(); wait_phase(2);
        @(negedge clk);
        chk("R9 no flush before resume", int'(fifo_flush), 0);
        rssi_hit = 1'b1;
        @(negedge clk);
        rssi_hit = 1'b0;
        rx_timeout = 1'b1;
        @(negedge clk);
        rx_timeout = 1'b0;
        chk("R9 resume to idle", int'(phase), 1);
        wait_phase(2);
        chk("R9 flush first rx cycle", int'(fifo_flush), 1);
        @(negedge clk);
        chk("R9 flush one cycle", int'(fifo_flush), 0);

        // R11: acceptance on the last window cycle beats expiry.
        end_act = 2'b01; rx_coef = 8'd1;
        restart(); wait_phase(2);
        rssi_hit = 1'b1;
        @(negedge clk);
        rssi_hit = 1'b0;
        chk("R11 accept beats expiry", int'(phase), 3);

        // R1: disable mid-window.
        rx_coef = 8'd10;
        restart(); wait_phase(2);
        listen_en = 1'b0;
        @(negedge clk);
        chk("R1 disable mid rx", int'(phase), 0);
        chk("R1 rx off after disable", int'(rx_on), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule